// File: doc/BRIEF.md
# Pipelined burst synchronous SRAM core

This block is a clocked word-addressed memory with registered address and control inputs, a four-beat burst address generator, and a two-stage pipelined read path. A burst begins when one of two start strobes is seen at a clock edge. The processor-side strobe always begins a read and is masked while the first chip select is high. The controller-side strobe begins a read or a write, depending on the write enables in the same cycle. The two low address bits of later beats come from a two-bit beat counter. That counter steps only on edges where the advance strobe is low. A static order input picks a linear or an interleaved walk through the aligned four-word group.

Writes take effect at the clock edge where the access address is formed. A global write enable covers the whole 18-bit word. Otherwise a byte-write enable, together with a per-lane enable, selects which of the two 9-bit lanes are written. Read data for an access address registered at edge k is driven after edge k+2. An active-low sleep input freezes all state and blocks every access. It also drops the output drive at once. The output enable gates the drive flag combinationally.

Top module: `psb_core`

## Requirements
- R1: With `order_sel` = 0 (linear), the four beats of a burst starting at word A use low bits (A[1:0]+n) mod 4 for n = 0..3, and the upper address bits stay those of A.
- R2: With `order_sel` = 1 (interleaved), beat n uses low bits A[1:0] XOR n, and the upper address bits stay those of A.
- R3: A burst starts on `proc_as_n` low (only while `cs1_n` is low) or on `ctrl_as_n` low. When both are valid in one cycle, the processor start wins. A processor strobe with `cs1_n` high leaves a running burst untouched.
- R4: Inside a burst the beat counter steps at an edge only when `adv_n` is low. With `adv_n` high the current word is accessed again.
- R5: With `gwr_n` low in an access that may write, both byte lanes (bits 8:0 and 17:9) are written from `din`.
- R6: With `gwr_n` high, lane i is written only when `bwr_n` is low and `lane_we_n[i]` is low. Lane 0 is bits 8:0 and lane 1 is bits 17:9.
- R7: An access with no lane write is a read. Its data appears on `dout`, with `dout_en` high, after the second clock edge following the edge that registered its address, and not before.
- R8: While `sleep_n` is low, no write lands and no state changes, and `dout_en` goes low without waiting for a clock edge.
- R9: `oe_n` high forces `dout_en` low combinationally. `oe_n` low restores it with no clock edge.
- R10: A start with the chip deselected (`cs1_n` high, `cs2` low or `cs3_n` high) performs no access: nothing is written and no read data is driven.
- R11: A processor-strobe start is always a read. Write enables in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_n | input | 1 | Power-down, active low: freezes state, blocks access |
| order_sel | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr | input | AW | Word address sampled on a start |
| cs1_n | input | 1 | Chip select 1, active low, also masks the processor strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| proc_as_n | input | 1 | Processor-side burst start strobe, active low |
| ctrl_as_n | input | 1 | Controller-side burst start strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| gwr_n | input | 1 | Global (all lanes) write enable, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Output drive flag (tri-state enable) |

## Verification
The processor and controller strobes can both arrive in one cycle. The bench does this with `gwr_n` low and fresh data on `din`, and judges the result by the data returned two edges later: if the old word comes back, the processor start won and was treated as a read. A read still in the pipeline can also meet a sleep request or a deasserted output enable. The bench checks that `dout_en` falls within a fraction of a cycle, before any clock edge, and that a write offered during sleep never reaches the array.

// File: rtl/psb_pkg.sv
package psb_pkg;

  // Burst walk selected by the static order input.
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } beat_order_e;

  localparam int unsigned BEAT_W = 2;

  // Low address bits used by beat 'beat' of a burst starting at 'start_ofs'.
  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start_ofs,
    input logic [BEAT_W-1:0] beat,
    input beat_order_e       ord
  );
    logic [BEAT_W-1:0] r;
    case (ord)
      ORD_XOR: r = start_ofs ^ beat;
      default: r = start_ofs + beat;
    endcase
    return r;
  endfunction

  // A lane is requested by the global write, or by byte write plus its own enable.
  function automatic logic lane_request(
    input logic gw_n,
    input logic bw_n,
    input logic lwe_n
  );
    return !gw_n || (!bw_n && !lwe_n);
  endfunction

endpackage

// File: rtl/psb_burst_ctrl.sv
module psb_burst_ctrl
  import psb_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic [AW-1:0]     addr_i,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              proc_as_n,
  input  logic              ctrl_as_n,
  input  logic              adv_n,
  input  beat_order_e       order,
  input  logic              any_wr_req,
  output logic [AW-1:0]     acc_addr,
  output logic              acc_rd,
  output logic              acc_wr_ok,
  output logic              proc_go,
  output logic              ctrl_go,
  output logic              start,
  output logic              step,
  output logic              chip_sel,
  output logic              active,
  output logic [BEAT_W-1:0] beat_cnt
);

  localparam int unsigned HI_W = AW - BEAT_W;

  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] cnt_nxt;
  logic              active_q;
  logic              access;
  logic [HI_W-1:0]   base_hi;
  logic [BEAT_W-1:0] base_lo;

  // Start decode: the processor strobe needs cs1_n low and wins a tie.
  always_comb begin
    proc_go  = !proc_as_n && !cs1_n;
    ctrl_go  = !ctrl_as_n && !proc_go;
    start    = proc_go || ctrl_go;
    chip_sel = !cs1_n && cs2 && !cs3_n;
    step     = !start && active_q && !adv_n;
  end

  // Beat counter: cleared on a start, stepped on advance, held otherwise.
  always_comb begin
    if (start) begin
      cnt_nxt = '0;
    end else if (step) begin
      cnt_nxt = cnt_q + BEAT_W'(1);
    end else begin
      cnt_nxt = cnt_q;
    end
  end

  assign base_hi = base_q[AW-1:BEAT_W];
  assign base_lo = base_q[BEAT_W-1:0];

  // Access address for this edge.
  always_comb begin
    if (start) begin
      acc_addr = addr_i;
    end else begin
      acc_addr = {base_hi, beat_offset(base_lo, cnt_nxt, order)};
    end
  end

  always_comb begin
    access    = awake && (start ? chip_sel : active_q);
    acc_wr_ok = access && !proc_go;
    acc_rd    = access && !(acc_wr_ok && any_wr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (awake) begin
      if (start) begin
        base_q   <= addr_i;
        active_q <= chip_sel;
      end
      cnt_q <= cnt_nxt;
    end
  end

  assign active   = active_q;
  assign beat_cnt = cnt_q;

endmodule

// File: rtl/psb_lane_dec.sv
module psb_lane_dec
  import psb_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             wr_ok,
  output logic [LANES-1:0] lane_req,
  output logic [LANES-1:0] lane_wr,
  output logic             any_req
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_req[g] = lane_request(gwr_n, bwr_n, lane_we_n[g]);
    assign lane_wr[g]  = lane_req[g] && wr_ok;
  end

  assign any_req = |lane_req;

endmodule

// File: rtl/psb_mem.sv
module psb_mem #(
  parameter int unsigned AW     = 4,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DEPTH = 1 << AW,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] lane_wr,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rdata
);

  // One storage column per byte lane, each with its own write strobe.
  for (genvar g = 0; g < LANES; g++) begin : g_col
    logic [LANE_W-1:0] col_q [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_wr[g]) begin
        col_q[wr_addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = col_q[rd_addr];
  end

endmodule

// File: rtl/psb_rd_pipe.sv
module psb_rd_pipe #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          awake,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr_i,
  output logic [AW-1:0] rd_addr_q,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);

  logic          v0_q;
  logic          v1_q;
  logic [DW-1:0] s1_q;

  // Address register, array stage, output stage; all frozen while asleep.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      v0_q      <= 1'b0;
      v1_q      <= 1'b0;
      s1_q      <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (awake) begin
      rd_addr_q <= rd_addr_i;
      v0_q      <= rd_req;
      s1_q      <= rdata;
      v1_q      <= v0_q;
      out_data  <= s1_q;
      out_valid <= v1_q;
    end
  end

endmodule

// File: rtl/psb_core.sv
module psb_core
  import psb_pkg::*;
#(
  parameter int unsigned AW     = 4,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_n,
  input  logic             order_sel,
  input  logic [AW-1:0]    addr,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             proc_as_n,
  input  logic             ctrl_as_n,
  input  logic             adv_n,
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             oe_n,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_en
);

  // Named internal events, visible to the bound checker.
  logic              proc_go;
  logic              ctrl_go;
  logic              start_evt;
  logic              step_evt;
  logic              chip_sel;
  logic              burst_active;
  logic [BEAT_W-1:0] beat_cnt;
  logic [AW-1:0]     acc_addr;
  logic              rd_req;
  logic              wr_ok;
  logic              any_wr_req;
  logic [LANES-1:0]  lane_req;
  logic [LANES-1:0]  lane_wr;
  logic [AW-1:0]     rd_addr_q;
  logic [DW-1:0]     rdata;
  logic              out_valid;

  psb_burst_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .awake      (sleep_n),
    .addr_i     (addr),
    .cs1_n      (cs1_n),
    .cs2        (cs2),
    .cs3_n      (cs3_n),
    .proc_as_n  (proc_as_n),
    .ctrl_as_n  (ctrl_as_n),
    .adv_n      (adv_n),
    .order      (beat_order_e'(order_sel)),
    .any_wr_req (any_wr_req),
    .acc_addr   (acc_addr),
    .acc_rd     (rd_req),
    .acc_wr_ok  (wr_ok),
    .proc_go    (proc_go),
    .ctrl_go    (ctrl_go),
    .start      (start_evt),
    .step       (step_evt),
    .chip_sel   (chip_sel),
    .active     (burst_active),
    .beat_cnt   (beat_cnt)
  );

  psb_lane_dec #(.LANES(LANES)) u_lanes (
    .gwr_n     (gwr_n),
    .bwr_n     (bwr_n),
    .lane_we_n (lane_we_n),
    .wr_ok     (wr_ok),
    .lane_req  (lane_req),
    .lane_wr   (lane_wr),
    .any_req   (any_wr_req)
  );

  psb_mem #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .lane_wr (lane_wr),
    .wr_addr (acc_addr),
    .wdata   (din),
    .rd_addr (rd_addr_q),
    .rdata   (rdata)
  );

  psb_rd_pipe #(.AW(AW), .DW(DW)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .awake     (sleep_n),
    .rd_req    (rd_req),
    .rd_addr_i (acc_addr),
    .rd_addr_q (rd_addr_q),
    .rdata     (rdata),
    .out_data  (dout),
    .out_valid (out_valid)
  );

  // Drive flag: asynchronous in both the output enable and sleep.
  assign dout_en = out_valid && !oe_n && sleep_n;

endmodule

// File: rtl/psb_core_chk.sv
module psb_core_chk #(
  parameter int unsigned AW     = 4,
  parameter int unsigned LANES  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_n,
  input logic             cs1_n,
  input logic             proc_as_n,
  input logic             adv_n,
  input logic             gwr_n,
  input logic             bwr_n,
  input logic             oe_n,
  input logic             dout_en,
  input logic             proc_go,
  input logic             ctrl_go,
  input logic             start_evt,
  input logic             step_evt,
  input logic             chip_sel,
  input logic             burst_active,
  input logic [1:0]       beat_cnt,
  input logic             rd_req,
  input logic             wr_ok,
  input logic [LANES-1:0] lane_wr,
  input logic             out_valid,
  input logic [AW-1:0]    acc_addr
);

  AST_PROC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_as_n && cs1_n) |-> !proc_go); // R3
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({proc_go, ctrl_go})); // R3
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && sleep_n) |=> (beat_cnt == $past(beat_cnt) + 2'd1)); // R4
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !start_evt && adv_n && sleep_n) |=> $stable(beat_cnt)); // R4
  AST_GLOBAL_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !gwr_n) |-> (&lane_wr)); // R5
  AST_NO_BYTE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (gwr_n && bwr_n) |-> (lane_wr == '0)); // R6
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && sleep_n) ##1 sleep_n ##1 sleep_n |=> out_valid); // R7
  AST_SLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> (lane_wr == '0 && !rd_req)); // R8
  AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> ($stable(beat_cnt) && $stable(burst_active) && $stable(out_valid))); // R8
  AST_SLEEP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> !dout_en); // R8
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !oe_n); // R9
  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !chip_sel) |-> (lane_wr == '0 && !rd_req)); // R10
  AST_PROC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    proc_go |-> (lane_wr == '0)); // R11
  AST_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !adv_n) |-> !$isunknown(acc_addr)); // R1 R2

endmodule

bind psb_core psb_core_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_n      (sleep_n),
  .cs1_n        (cs1_n),
  .proc_as_n    (proc_as_n),
  .adv_n        (adv_n),
  .gwr_n        (gwr_n),
  .bwr_n        (bwr_n),
  .oe_n         (oe_n),
  .dout_en      (dout_en),
  .proc_go      (proc_go),
  .ctrl_go      (ctrl_go),
  .start_evt    (start_evt),
  .step_evt     (step_evt),
  .chip_sel     (chip_sel),
  .burst_active (burst_active),
  .beat_cnt     (beat_cnt),
  .rd_req       (rd_req),
  .wr_ok        (wr_ok),
  .lane_wr      (lane_wr),
  .out_valid    (out_valid),
  .acc_addr     (acc_addr)
);

// File: tb/psb_core_tb.sv
module psb_core_tb;

  localparam int AW = 4;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep_n, order_sel, cs1_n, cs2, cs3_n;
  logic          proc_as_n, ctrl_as_n, adv_n, gwr_n, bwr_n, oe_n;
  logic [1:0]    lane_we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4ns clk = ~clk;

  psb_core u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .order_sel(order_sel),
    .addr(addr), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .proc_as_n(proc_as_n), .ctrl_as_n(ctrl_as_n), .adv_n(adv_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_we_n(lane_we_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  typedef struct packed {
    logic       ilv;
    logic       use_proc;
    logic [3:0] base;
    logic [1:0] o0, o1, o2, o3;
  } vec_t;

  // Burst vectors: order, start strobe, start word, expected low bits per beat (R1, R2).
  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b1, 4'h0, 2'd0, 2'd1, 2'd2, 2'd3},
    '{1'b0, 1'b0, 4'h5, 2'd1, 2'd2, 2'd3, 2'd0},
    '{1'b0, 1'b1, 4'hB, 2'd3, 2'd0, 2'd1, 2'd2},
    '{1'b1, 1'b0, 4'h1, 2'd1, 2'd0, 2'd3, 2'd2},
    '{1'b1, 1'b1, 4'h6, 2'd2, 2'd3, 2'd0, 2'd1},
    '{1'b1, 1'b0, 4'hF, 2'd3, 2'd2, 2'd1, 2'd0},
    '{1'b0, 1'b0, 4'hA, 2'd2, 2'd3, 2'd0, 2'd1},
    '{1'b1, 1'b1, 4'h8, 2'd0, 2'd1, 2'd2, 2'd3}
  };

  function automatic logic [DW-1:0] pat(input logic [3:0] a);
    return {a, 5'h15, a, ~a, 1'b1};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_ctl();
    proc_as_n = 1'b1; ctrl_as_n = 1'b1; adv_n = 1'b1;
    gwr_n = 1'b1; bwr_n = 1'b1; lane_we_n = 2'b11;
    cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d,
                    input logic gw, input logic bw, input logic [1:0] lw);
    ctrl_as_n = 1'b0; addr = a; din = d; gwr_n = gw; bwr_n = bw; lane_we_n = lw;
    tick();
    idle_ctl();
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] d, output logic en);
    ctrl_as_n = 1'b0; addr = a;
    tick();
    idle_ctl();
    tick();
    tick();
    d = dout; en = dout_en;
  endtask

  initial begin
    #200us;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic          en;
    logic [3:0]    a;
    logic [1:0]    ord [4];

    rst_n = 1'b0; sleep_n = 1'b1; order_sel = 1'b0; oe_n = 1'b0;
    addr = '0; din = '0;
    idle_ctl();
    tick(); tick();
    chk(dout_en == 1'b0, "R7 reset drive", {17'b0, dout_en}, '0);
    rst_n = 1'b1;
    tick();
    chk(dout_en == 1'b0, "R7 idle after reset", {17'b0, dout_en}, '0);

    // Fill every word through global writes.
    for (int i = 0; i < 16; i++) wr(4'(i), pat(4'(i)), 1'b0, 1'b1, 2'b11);

    // Vector table walk: four-beat bursts, both orders and both strobes.
    for (int v = 0; v < 8; v++) begin
      order_sel = VEC[v].ilv;
      ord[0] = VEC[v].o0; ord[1] = VEC[v].o1; ord[2] = VEC[v].o2; ord[3] = VEC[v].o3;
      addr = VEC[v].base;
      if (VEC[v].use_proc) proc_as_n = 1'b0; else ctrl_as_n = 1'b0;
      tick();
      idle_ctl();
      for (int t = 1; t <= 5; t++) begin
        adv_n = (t <= 3) ? 1'b0 : 1'b1;
        tick();
        if (t >= 2) begin
          a = {VEC[v].base[3:2], ord[t-2]};
          chk(dout_en && dout == pat(a), VEC[v].ilv ? "R2 interleaved beat" : "R1 linear beat",
              dout, pat(a));
        end
      end
      idle_ctl();
    end
    order_sel = 1'b0;

    // R4: advance held high repeats the word.
    proc_as_n = 1'b0; addr = 4'h4;
    tick(); idle_ctl();
    adv_n = 1'b1; tick();
    adv_n = 1'b0; tick();
    adv_n = 1'b1; tick();
    chk(dout == pat(4'h4), "R4 hold beat", dout, pat(4'h4));
    tick();
    chk(dout == pat(4'h5), "R4 step after hold", dout, pat(4'h5));
    idle_ctl();

    // R5: global write overrides lane enables.
    wr(4'h5, 18'h3ABCD, 1'b0, 1'b1, 2'b11);
    rd(4'h5, d, en);
    chk(en && d == 18'h3ABCD, "R5 global write", d, 18'h3ABCD);

    // R6: per-lane writes.
    wr(4'h6, 18'h15555, 1'b1, 1'b0, 2'b10);
    rd(4'h6, d, en);
    chk(d == {pat(4'h6)[17:9], 9'h155}, "R6 lane0 only", d, {pat(4'h6)[17:9], 9'h155});
    wr(4'h6, 18'h00000, 1'b1, 1'b1, 2'b00);
    rd(4'h6, d, en);
    chk(d == {pat(4'h6)[17:9], 9'h155}, "R6 byte enable off", d, {pat(4'h6)[17:9], 9'h155});
    wr(4'hC, 18'h2AAAA, 1'b1, 1'b0, 2'b01);
    rd(4'hC, d, en);
    chk(d == {9'h155, pat(4'hC)[8:0]}, "R6 lane1 only", d, {9'h155, pat(4'hC)[8:0]});

    // R10: deselected start with write enables set.
    ctrl_as_n = 1'b0; cs2 = 1'b0; addr = 4'h7; din = 18'h00F0F; gwr_n = 1'b0;
    tick(); idle_ctl();
    tick(); tick(); tick();
    chk(dout_en == 1'b0, "R10 no read drive", {17'b0, dout_en}, '0);

    // R11 and R7: processor start with write enables is a read, two edges of latency.
    proc_as_n = 1'b0; addr = 4'h8; din = 18'h00F0F; gwr_n = 1'b0;
    tick(); idle_ctl();
    chk(dout_en == 1'b0, "R7 not before second edge", {17'b0, dout_en}, '0);
    tick();
    chk(dout_en == 1'b0, "R7 not after first edge", {17'b0, dout_en}, '0);
    tick();
    chk(dout_en && dout == pat(4'h8), "R11 proc start reads", dout, pat(4'h8));
    rd(4'h7, d, en);
    chk(d == pat(4'h7), "R10 no write when deselected", d, pat(4'h7));

    // R3: both strobes with write enables: processor start wins, so no write.
    proc_as_n = 1'b0; ctrl_as_n = 1'b0; addr = 4'hB; din = 18'h00F0F; gwr_n = 1'b0;
    tick(); idle_ctl();
    tick(); tick();
    chk(dout_en && dout == pat(4'hB), "R3 tie goes to processor", dout, pat(4'hB));

    // R3: processor strobe with cs1_n high leaves a running burst alone.
    rd(4'hA, d, en);
    proc_as_n = 1'b0; cs1_n = 1'b1; addr = 4'h3;
    tick(); idle_ctl();
    tick(); tick();
    chk(dout_en && dout == pat(4'hA), "R3 masked processor strobe", dout, pat(4'hA));

    // R9: output enable acts without a clock edge.
    oe_n = 1'b1; #1ns;
    chk(dout_en == 1'b0, "R9 oe off", {17'b0, dout_en}, '0);
    oe_n = 1'b0; #1ns;
    chk(dout_en == 1'b1, "R9 oe on", {17'b0, dout_en}, 18'h1);

    // R8: sleep drops drive at once and blocks a write.
    sleep_n = 1'b0; #1ns;
    chk(dout_en == 1'b0, "R8 drive off in sleep", {17'b0, dout_en}, '0);
    tick();
    ctrl_as_n = 1'b0; addr = 4'h9; din = 18'h00F0F; gwr_n = 1'b0;
    tick(); idle_ctl(); tick();
    sleep_n = 1'b1;
    rd(4'h9, d, en);
    chk(en && d == pat(4'h9), "R8 write blocked in sleep", d, pat(4'h9));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule